// File: doc/BRIEF.md
# I2C Serial Clock Prescaler

This block turns a fast system clock into the timing strobes that an I2C master's bit engine runs on. The division happens in two stages in series. A linear stage divides by (M+1). A power-of-two stage then divides that result by 2^N, or by 2^(N+1). A single convention input chooses between the two exponents. The output of the second stage is an oversample tick that runs at ten times the bus bit rate. A decade counter divides the ticks by ten to give a bit-period strobe, which the bit engine uses to advance the SCL phase.

Both factors come from one 7-bit configuration word, which is loaded with a write strobe. Loading the word restarts every counter, so the first interval after a change already uses the new ratio. An enable input holds the whole chain idle. At reset the configuration gives a conservative rate: M=12 and N=2 give a tick every 104 system cycles, which is under 100 kHz on the bus at a 100 MHz system clock. Software is expected to pick the fastest setting that does not exceed the rate it wants.

Top module: `i2c_sclk_div`

## Requirements
- R1: After a synchronous reset, the configuration holds M=12 and N=2, and no tick or strobe is issued while reset is held. With the default convention, the first tick after reset is released falls in the 104th cycle.
- R2: In the configuration word, N is bits [2:0] and M is bits [6:3].
- R3: With the convention input low, the tick period is (M+1)·2^(N+1) system cycles.
- R4: With the convention input high, the tick period is (M+1)·2^N system cycles. With M=0 and N=0 the tick is high on every cycle.
- R5: The bit strobe pulses together with every tenth tick. After a restart, the first strobe falls in cycle 10·P, where P is the tick period.
- R6: A configuration write clears all counters. No tick is issued in the write cycle. The first tick with the new setting falls in the P-th cycle after the write edge.
- R7: While the enable is low, all counters stay at zero and no tick or strobe is issued. Once the enable goes high, the first tick falls in its P-th cycle.
- R8: Between two ticks there are exactly P-1 cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable; when low, all counters are held at zero |
| exp_base0_i | input | 1 | Convention select: 1 divides by 2^N, 0 divides by 2^(N+1) |
| cfg_we_i | input | 1 | One-cycle write strobe for the configuration word |
| cfg_wdata_i | input | 7 | Configuration word: M in [6:3], N in [2:0] |
| os_tick_o | output | 1 | Oversample tick at ten times the bit rate |
| bit_stb_o | output | 1 | Bit-period strobe, on every tenth tick |

## Verification
Every result is counted from a restart point: a write edge, the release of reset, or the first cycle in which the enable is high. The counters are zero in the first cycle after that point. The tick is therefore due in the P-th sampled cycle, the next tick P cycles later, and the bit strobe in cycle 10·P. The bench drives inputs and samples outputs on the falling edge. It numbers the cycles from the restart point and compares each measured cycle number with the value computed from M, N and the convention. The write-cycle suppression is checked within the same half cycle in which the strobe is raised.

// File: rtl/i2c_div_pkg.sv
// Shared widths and the configuration word type for the I2C clock prescaler.
// Assumes M sits above N in the configuration word, as software writes it.
package i2c_div_pkg;
    localparam int M_W    = 4;              // width of linear factor M
    localparam int N_W    = 3;              // width of exponent N
    localparam int CFG_W  = M_W + N_W;      // configuration word width
    localparam int EXP_W  = N_W + 1;        // exponent incl. the +1 convention
    localparam int POW_W  = 1 << N_W;       // counter bits for 2^(max N + 1)
    localparam int OVS    = 10;             // ticks per bit period
    localparam int DEC_W  = $clog2(OVS);

    typedef struct packed {
        logic [M_W-1:0] m;                  // bits [6:3]
        logic [N_W-1:0] n;                  // bits [2:0]
    } div_cfg_t;
endpackage

// File: rtl/i2c_div_cfg.sv
// Configuration capture: holds the M/N word, loads it on a write strobe.
// Assumes the write strobe is a single-cycle pulse from the register file.
module i2c_div_cfg
    import i2c_div_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = 7'h62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output div_cfg_t         cfg_o
);
    div_cfg_t cfg_q;

    // Capture the configuration word on a write, return to default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= div_cfg_t'(RESET_CFG);
        else if (we_i) cfg_q <= div_cfg_t'(wdata_i);
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/i2c_div_lin.sv
// Linear stage: issues a step once every (M+1) enabled cycles.
// Assumes M changes only together with a clear, so the count never exceeds M.
module i2c_div_lin
    import i2c_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           clr_i,
    input  logic [M_W-1:0] m_i,
    output logic [M_W-1:0] cnt_o,
    output logic           step_o
);
    logic [M_W-1:0] cnt_q;

    assign step_o = en_i && !clr_i && (cnt_q >= m_i);
    assign cnt_o  = cnt_q;

    // Count 0..M, wrapping on each step; held at zero when idle or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) cnt_q <= '0;
        else if (step_o)              cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    // R7: a low enable leaves the linear counter at zero on the next cycle
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
    // R3: the count never passes the configured M
    a_r3_lin_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_i);
endmodule

// File: rtl/i2c_div_pow.sv
// Power-of-two stage: issues a tick after 2^E linear steps, E = N or N+1.
// Assumes the exponent may change without a clear; it wraps on >= the last value.
module i2c_div_pow
    import i2c_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [POW_W-1:0] cnt_o,
    output logic             tick_o
);
    logic [POW_W-1:0] cnt_q;
    logic [POW_W-1:0] last;

    // Terminal count 2^E - 1 as a mask of E low ones.
    always_comb begin
        for (int i = 0; i < POW_W; i++)
            last[i] = (EXP_W'(i) < exp_i);
    end

    assign tick_o = step_i && (cnt_q >= last);
    assign cnt_o  = cnt_q;

    // Count linear steps, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) cnt_q <= '0;
        else if (tick_o)              cnt_q <= '0;
        else if (step_i)              cnt_q <= cnt_q + 1'b1;
    end

    // R7: a low enable leaves the exponent counter at zero on the next cycle
    a_r7_pow_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_div_dec.sv
// Decade stage: counts oversample ticks and strobes on every OVS-th one.
// Assumes the tick input is already qualified by enable and clear.
module i2c_div_dec
    import i2c_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic bit_stb_o
);
    localparam logic [DEC_W-1:0] LAST = DEC_W'(OVS - 1);
    logic [DEC_W-1:0] cnt_q;

    assign bit_stb_o = tick_i && (cnt_q == LAST);

    // Count ticks 0..OVS-1; cleared with the rest of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) cnt_q <= '0;
        else if (tick_i)              cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R5: the decade count stays within one bit period
    a_r5_dec_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/i2c_sclk_div.sv
// Top of the I2C serial clock prescaler: config capture, (M+1) stage,
// 2^N or 2^(N+1) stage and decade strobe. Assumes a single clock domain.
module i2c_sclk_div
    import i2c_div_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = 7'h62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             exp_base0_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             os_tick_o,
    output logic             bit_stb_o
);
    div_cfg_t         cfg;
    logic             lin_step;
    logic [M_W-1:0]   lin_cnt;
    logic [POW_W-1:0] pow_cnt;
    logic [EXP_W-1:0] exp_sel;

    // Exponent: N for the base-zero convention, N+1 otherwise.
    assign exp_sel = {1'b0, cfg.n} + (exp_base0_i ? EXP_W'(0) : EXP_W'(1));

    i2c_div_cfg #(.RESET_CFG(RESET_CFG)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
        .cfg_o(cfg)
    );

    i2c_div_lin u_lin (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(cfg_we_i),
        .m_i(cfg.m), .cnt_o(lin_cnt), .step_o(lin_step)
    );

    i2c_div_pow u_pow (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(cfg_we_i),
        .step_i(lin_step), .exp_i(exp_sel), .cnt_o(pow_cnt), .tick_o(os_tick_o)
    );

    i2c_div_dec u_dec (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(cfg_we_i),
        .tick_i(os_tick_o), .bit_stb_o(bit_stb_o)
    );

    // R6: a write leaves both prescale counters at zero on the next cycle
    a_r6_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (lin_cnt == '0 && pow_cnt == '0));
    // R6: no tick is issued during a write cycle
    a_r6_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |-> !os_tick_o);
endmodule

// File: tb/i2c_sclk_div_tb_top.sv
module i2c_sclk_div_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b1;
    logic       exp_base0_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [6:0] cfg_wdata_i = '0;
    logic       os_tick_o, bit_stb_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_sclk_div dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .exp_base0_i(exp_base0_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .os_tick_o(os_tick_o), .bit_stb_o(bit_stb_o)
    );

    // base, M, N, expected tick period
    localparam int VEC [0:7][0:3] = '{
        '{0, 0, 0, 2},    '{1, 0, 0, 1},
        '{0, 3, 2, 32},   '{1, 3, 2, 16},
        '{0, 15, 7, 4096}, '{1, 15, 0, 16},
        '{0, 1, 1, 8},    '{1, 5, 3, 48}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Write the configuration at a falling edge; return just after the next one.
    task automatic wr_cfg(input bit base, input int m, input int n);
        @(negedge clk);
        exp_base0_i = base;
        cfg_wdata_i = {m[3:0], n[2:0]};
        cfg_we_i    = 1'b1;
        @(negedge clk);
        cfg_we_i    = 1'b0;
        #1;
    endtask

    // Count sampled cycles from now (cycle 1) up to limit; report first tick,
    // second tick and first bit strobe cycle numbers (0 if none).
    task automatic measure(input int limit, output int ft, output int st, output int bt);
        ft = 0; st = 0; bt = 0;
        for (int c = 1; c <= limit; c++) begin
            if (os_tick_o) begin
                if (ft == 0) ft = c;
                else if (st == 0) st = c;
            end
            if (bit_stb_o && bt == 0) bt = c;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int ft, st, bt, p, quiet;
        // R1: outputs quiet in reset, first tick at 104 after release
        repeat (3) @(negedge clk);
        #1;
        chk(!os_tick_o && !bit_stb_o, "R1 reset outputs", os_tick_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        measure(110, ft, st, bt);
        chk(ft == 104, "R1 first tick after reset", ft, 104);

        // R2 R3 R4 R5 R8: vector table
        for (int v = 0; v < 8; v++) begin
            p = VEC[v][3];
            wr_cfg(VEC[v][0] != 0, VEC[v][1], VEC[v][2]);
            measure(10 * p + 1, ft, st, bt);
            chk(ft == p, VEC[v][0] ? "R4 R6 first tick" : "R3 R6 first tick", ft, p);
            chk(st - ft == p, "R8 R2 tick gap", st - ft, p);
            chk(bt == 10 * p, "R5 first bit strobe", bt, 10 * p);
        end

        // R6: rewrite mid-count restarts the interval
        wr_cfg(0, 3, 2);
        repeat (20) @(negedge clk);
        wr_cfg(0, 3, 2);
        measure(40, ft, st, bt);
        chk(ft == 32, "R6 restart on rewrite", ft, 32);

        // R6: no tick in the write cycle, even at P=1
        wr_cfg(1, 0, 0);
        chk(os_tick_o, "R4 tick every cycle", os_tick_o, 1);
        @(negedge clk);
        cfg_we_i = 1'b1;
        #1;
        chk(!os_tick_o, "R6 quiet write cycle", os_tick_o, 0);
        @(negedge clk);
        cfg_we_i = 1'b0;
        #1;
        chk(os_tick_o, "R6 tick after write", os_tick_o, 1);

        // R7: enable low stops everything, restart from zero
        wr_cfg(1, 1, 2);
        @(negedge clk);
        en_i = 1'b0;
        #1;
        quiet = 0;
        for (int c = 0; c < 50; c++) begin
            if (os_tick_o || bit_stb_o) quiet++;
            @(negedge clk);
            #1;
        end
        chk(quiet == 0, "R7 no tick while disabled", quiet, 0);
        @(negedge clk);
        en_i = 1'b1;
        #1;
        measure(90, ft, st, bt);
        chk(ft == 8, "R7 first tick after enable", ft, 8);
        chk(bt == 80, "R7 R5 first strobe after enable", bt, 80);

        summary();
    end
endmodule